// File: doc/BRIEF.md
# Late-Write Synchronous SRAM Core

A synchronous static RAM whose writes use late-write timing. On every rising clock edge the core registers the address, the select, the read/write command and the per-lane write enables. The data for a write does not arrive with its command. It arrives on the next rising edge and is held in a one-entry pending-write buffer. That buffer is retired into the storage array when the data of the following write is captured. A read whose address matches the pending entry gets the buffered lanes for the enabled positions and the array contents for the rest, so no reader ever sees a stale word.

Read data comes from an output register. An asynchronous output enable gates it onto the data output and a drive flag. The word is built from 9-bit lanes. `ORG_WIDE=1` gives four lanes and a 36-bit word. `ORG_WIDE=0` gives two lanes and an 18-bit word. `ADDR_W` sets the depth: 15 for the wide organisation and 16 for the narrow one in a full-size build. The default is kept small so that the model elaborates quickly.

Top module: `lw_sram_core`

## Requirements
- R1: When `rst_ni` is low the output register clears asynchronously. After reset, with `oe_i` high and no command pending, `rdata_o` is all zeros and `drive_o` is 1.
- R2: A read (`sel_i`=1, `wr_i`=0) captured at edge N updates `rdata_o` after edge N+1. After edge N itself the output still shows the previous register value.
- R3: The write data for a write captured at edge N is taken from `wdata_i` at edge N+1. The value on `wdata_i` at edge N is ignored.
- R4: Lane k of the word is bits [9k+8:9k], and `be_i[k]`=1 enables lane k. A write changes only its enabled lanes.
- R5: A read of the address held in the pending buffer returns the buffered lanes wherever the pending enable is set, and the array lanes elsewhere.
- R6: A pending write is committed to the array when the next write's data is captured. Reads after that commit return the committed word.
- R7: A cycle with `sel_i`=0 performs no read and no write and leaves the output register unchanged. The data of a write issued on the previous edge is still captured on that edge.
- R8: With `oe_i` low, `rdata_o` is all zeros and `drive_o` is 0 at once, without waiting for a clock edge. Raising `oe_i` restores the register value at once.
- R9: During the cycle in which write data is expected (after a write command edge), `drive_o` is 0 and `rdata_o` is all zeros.
- R10: A write with all lane enables at 0 leaves the stored word unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Synchronous select, 1 = cycle active |
| wr_i | input | 1 | Command: 1 = write, 0 = read |
| addr_i | input | ADDR_W | Word address |
| be_i | input | LANES | Per-lane write enables |
| wdata_i | input | DW | Write data, one cycle after its command |
| oe_i | input | 1 | Asynchronous output enable |
| rdata_o | output | DW | Gated read data, zero when not driven |
| drive_o | output | 1 | 1 when the output register is driven |

## Verification
The hardest case to reach from the ports is a read that hits a partially enabled pending entry while the array holds a different, fully defined word at the same address. The stimulus table reaches it in stages. It first writes a full word. It then issues a two-lane write to the same address, so the full word is committed as the second write's data arrives. It then reads that address before any further write retires the buffer. Later rows repeat the pattern with a single-lane write and with an all-disabled write, and they place a deselected cycle between a write command and its data.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;
  localparam int LANE_W = 9;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/lw_sram_cmd.sv
module lw_sram_cmd
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LANES-1:0]  be_i,
  output op_e               op_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [LANES-1:0]  be_o
);
  op_e op_d;

  always_comb begin
    if (!sel_i)    op_d = OP_IDLE;
    else if (wr_i) op_d = OP_WRITE;
    else           op_d = OP_READ;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_o   <= OP_IDLE;
      addr_o <= '0;
      be_o   <= '0;
    end else begin
      op_o   <= op_d;
      addr_o <= addr_i;
      be_o   <= be_i;
    end
  end
endmodule

// File: rtl/lw_sram_wbuf.sv
module lw_sram_wbuf
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  localparam int DW    = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  op_e               op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LANES-1:0]  be_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [DW-1:0]     arr_rdata_i,
  output logic              commit_o,
  output logic [ADDR_W-1:0] commit_addr_o,
  output logic [LANES-1:0]  commit_be_o,
  output logic [DW-1:0]     commit_data_o,
  output logic [DW-1:0]     fwd_data_o,
  output logic              pend_vld_o
);
  logic [ADDR_W-1:0] pend_addr;
  logic [LANES-1:0]  pend_be;
  logic [DW-1:0]     pend_data;
  logic              capture;
  logic              hit;

  assign capture = (op_i == OP_WRITE);
  // retire the older entry on the edge the newer one lands
  assign commit_o      = capture && pend_vld_o;
  assign commit_addr_o = pend_addr;
  assign commit_be_o   = pend_be;
  assign commit_data_o = pend_data;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_vld_o <= 1'b0;
      pend_addr  <= '0;
      pend_be    <= '0;
      pend_data  <= '0;
    end else if (capture) begin
      pend_vld_o <= 1'b1;
      pend_addr  <= addr_i;
      pend_be    <= be_i;
      pend_data  <= wdata_i;
    end
  end

  assign hit = pend_vld_o && (pend_addr == addr_i);

  for (genvar k = 0; k < LANES; k++) begin : g_fwd
    assign fwd_data_o[k*LANE_W +: LANE_W] = (hit && pend_be[k]) ?
        pend_data[k*LANE_W +: LANE_W] : arr_rdata_i[k*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/lw_sram_array.sv
module lw_sram_array
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  localparam int DW    = LANES * LANE_W,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [LANES-1:0]  wbe_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DW-1:0]     rdata_o
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk_i) begin
      if (we_i && wbe_i[k]) mem[waddr_i] <= wdata_i[k*LANE_W +: LANE_W];
    end

    assign rdata_o[k*LANE_W +: LANE_W] = mem[raddr_i];
  end
endmodule

// File: rtl/lw_sram_out.sv
module lw_sram_out #(
  parameter int DW = 36
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] din_i,
  input  logic          oe_i,
  input  logic          wphase_i,
  output logic [DW-1:0] dout_o,
  output logic [DW-1:0] rdata_o,
  output logic          drive_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     dout_o <= '0;
    else if (load_i) dout_o <= din_i;
  end

  assign drive_o = oe_i && !wphase_i;
  assign rdata_o = drive_o ? dout_o : '0;
endmodule

// File: rtl/lw_sram_core.sv
module lw_sram_core
  import lw_sram_pkg::*;
#(
  parameter bit  ORG_WIDE = 1'b1,
  parameter int  ADDR_W   = 8,
  localparam int LANES    = ORG_WIDE ? 4 : 2,
  localparam int DW       = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LANES-1:0]  be_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              oe_i,
  output logic [DW-1:0]     rdata_o,
  output logic              drive_o
);
  op_e               op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LANES-1:0]  be_q;
  logic              commit;
  logic [ADDR_W-1:0] commit_addr;
  logic [LANES-1:0]  commit_be;
  logic [DW-1:0]     commit_data;
  logic [DW-1:0]     arr_rdata;
  logic [DW-1:0]     fwd_data;
  logic              pend_vld;
  logic [DW-1:0]     dout_q;

  lw_sram_cmd #(.ADDR_W(ADDR_W), .LANES(LANES)) u_cmd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (sel_i),
    .wr_i   (wr_i),
    .addr_i (addr_i),
    .be_i   (be_i),
    .op_o   (op_q),
    .addr_o (addr_q),
    .be_o   (be_q)
  );

  lw_sram_wbuf #(.ADDR_W(ADDR_W), .LANES(LANES)) u_wbuf (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .op_i          (op_q),
    .addr_i        (addr_q),
    .be_i          (be_q),
    .wdata_i       (wdata_i),
    .arr_rdata_i   (arr_rdata),
    .commit_o      (commit),
    .commit_addr_o (commit_addr),
    .commit_be_o   (commit_be),
    .commit_data_o (commit_data),
    .fwd_data_o    (fwd_data),
    .pend_vld_o    (pend_vld)
  );

  lw_sram_array #(.ADDR_W(ADDR_W), .LANES(LANES)) u_array (
    .clk_i   (clk_i),
    .we_i    (commit),
    .waddr_i (commit_addr),
    .wbe_i   (commit_be),
    .wdata_i (commit_data),
    .raddr_i (addr_q),
    .rdata_o (arr_rdata)
  );

  lw_sram_out #(.DW(DW)) u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (op_q == OP_READ),
    .din_i    (fwd_data),
    .oe_i     (oe_i),
    .wphase_i (op_q == OP_WRITE),
    .dout_o   (dout_q),
    .rdata_o  (rdata_o),
    .drive_o  (drive_o)
  );
endmodule

// File: rtl/lw_sram_chk.sv
module lw_sram_chk #(
  parameter int DW = 36
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          sel_i,
  input logic          wr_i,
  input logic          oe_i,
  input logic [DW-1:0] rdata_o,
  input logic          drive_o,
  input logic [DW-1:0] dout_q,
  input logic          pend_vld
);
  // R8
  oe_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_i |-> (rdata_o == '0 && !drive_o));

  // R9
  wphase_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && wr_i) |=> !drive_o);

  // R7
  desel_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |=> ##1 $stable(dout_q));

  // R3
  data_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && wr_i) |=> ##1 pend_vld);

  // R6
  pend_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_vld |=> pend_vld);
endmodule

bind lw_sram_core lw_sram_chk #(.DW(DW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .sel_i    (sel_i),
  .wr_i     (wr_i),
  .oe_i     (oe_i),
  .rdata_o  (rdata_o),
  .drive_o  (drive_o),
  .dout_q   (dout_q),
  .pend_vld (pend_vld)
);

// File: tb/lw_sram_core_tb.sv
module lw_sram_core_tb_top;
  localparam int AW = 8;
  localparam int DW = 36;

  localparam logic [DW-1:0] D1  = 36'h123456789;
  localparam logic [DW-1:0] D2  = 36'hFFFFFFFFF;
  localparam logic [DW-1:0] D3  = 36'h9A5C3E1B7;
  localparam logic [DW-1:0] D5  = 36'h0DEADBEEF;
  localparam logic [DW-1:0] M02 = 36'h007FC01FF;  // lanes 0 and 2
  localparam logic [DW-1:0] L3  = 36'hFF8000000;  // lane 3
  localparam logic [DW-1:0] MRG = (D1 & ~M02) | (D2 & M02);
  localparam logic [DW-1:0] MR3 = MRG & ~L3;

  typedef struct packed {
    logic          sel;
    logic          wr;
    logic [AW-1:0] addr;
    logic [3:0]    be;
    logic [DW-1:0] wd;
    logic          chk;
    logic [DW-1:0] exp;
    logic [3:0]    req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 1'b1, 8'd5, 4'hF, 36'h0, 1'b0, 36'h0, 4'd0},
    '{1'b1, 1'b0, 8'd5, 4'h0, D1,    1'b0, 36'h0, 4'd0},
    '{1'b0, 1'b0, 8'd0, 4'h0, 36'h0, 1'b1, D1,    4'd5},  // R5 full hit
    '{1'b1, 1'b1, 8'd5, 4'h5, 36'h0, 1'b1, 36'h0, 4'd9},  // R9
    '{1'b1, 1'b0, 8'd5, 4'h0, D2,    1'b1, D1,    4'd2},  // R2 not yet
    '{1'b0, 1'b0, 8'd0, 4'h0, 36'h0, 1'b1, MRG,   4'd5},  // R5 partial
    '{1'b1, 1'b1, 8'd9, 4'hF, 36'h0, 1'b1, 36'h0, 4'd9},
    '{1'b1, 1'b1, 8'd5, 4'h8, D3,    1'b1, 36'h0, 4'd9},
    '{1'b1, 1'b0, 8'd9, 4'h0, 36'h0, 1'b1, MRG,   4'd2},
    '{1'b1, 1'b0, 8'd5, 4'h0, 36'h0, 1'b1, D3,    4'd3},  // R3 / R6
    '{1'b0, 1'b0, 8'd0, 4'h0, 36'h0, 1'b1, MR3,   4'd4},  // R4 lane 3
    '{1'b1, 1'b1, 8'd9, 4'h0, 36'h0, 1'b1, 36'h0, 4'd9},
    '{1'b0, 1'b0, 8'd0, 4'h0, D5,    1'b1, MR3,   4'd7},  // R7
    '{1'b1, 1'b0, 8'd5, 4'h0, 36'h0, 1'b1, MR3,   4'd2},
    '{1'b1, 1'b0, 8'd9, 4'h0, 36'h0, 1'b1, MR3,   4'd6},  // R6
    '{1'b0, 1'b0, 8'd0, 4'h0, 36'h0, 1'b1, D3,    4'd10}  // R10
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          sel_i = 1'b0;
  logic          wr_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [3:0]    be_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic          oe_i = 1'b1;
  logic [DW-1:0] rdata_o;
  logic          drive_o;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;

  always #2 clk_i = ~clk_i;

  lw_sram_core #(.ORG_WIDE(1'b1), .ADDR_W(AW)) dut_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (sel_i),
    .wr_i    (wr_i),
    .addr_i  (addr_i),
    .be_i    (be_i),
    .wdata_i (wdata_i),
    .oe_i    (oe_i),
    .rdata_o (rdata_o),
    .drive_o (drive_o)
  );

  task automatic check(input logic [DW-1:0] act, input logic [DW-1:0] exp,
                       input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 5000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual cycle %0d expected under 5000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk_i);
    // R1 reset state
    check(rdata_o, '0, "R1");
    check({35'd0, drive_o}, 36'd1, "R1");
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      sel_i   = TBL[i].sel;
      wr_i    = TBL[i].wr;
      addr_i  = TBL[i].addr;
      be_i    = TBL[i].be;
      wdata_i = TBL[i].wd;
      @(negedge clk_i);
      if (TBL[i].chk) check(rdata_o, TBL[i].exp, $sformatf("R%0d", TBL[i].req));
    end

    // R8 asynchronous gating, output register holds D3
    oe_i = 1'b0;
    #1;
    check(rdata_o, '0, "R8");
    check({35'd0, drive_o}, 36'd0, "R8");
    oe_i = 1'b1;
    #0.5;
    check(rdata_o, D3, "R8");

    // R1 asynchronous reset mid-cycle
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check(rdata_o, '0, "R1");
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(rdata_o, '0, "R1");

    // R2 array survives reset; read of addr 9 after reset
    sel_i = 1'b1; wr_i = 1'b0; addr_i = 8'd9;
    @(negedge clk_i);
    check(rdata_o, '0, "R2");
    sel_i = 1'b0;
    @(negedge clk_i);
    check(rdata_o, D3, "R2");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule